// File: doc/BRIEF.md
# Ethernet Receive Frame Checker

This block sits between a line decoder and a frame buffer. It takes a serial NRZ bit stream, qualified by a carrier-valid strobe, and searches it for the start-of-frame delimiter. Once the delimiter is found, it packs the following bits into bytes. It compares the six-byte destination address with the station's own address and then decides whether the frame is stored. Only frames that pass this filter appear on the byte output, framed by start and end markers.

A six-entry byte delay line holds back the start of each frame until the filter has decided. The same delay line lets the four trailing check bytes be dropped once the block knows where the frame ends. A control input chooses whether those four bytes are forwarded. A CRC-32 residue check and a length count run over every received byte. Their results are reported as event flags in the same cycle as the end marker.

Top module: `eth_rx_checker`

## Requirements
- R1: Frame data begins with the first bit after the last eight arrived bits read 1,0,1,0,1,0,1,1 in arrival order. Bits before that point, including any length of alternating preamble, produce no output.
- R2: Bytes are assembled least significant bit first, so the first bit received after the delimiter lands in bit 0. Bytes leave `rx_byte` in arrival order.
- R3: A frame ends on the first cycle with `bit_vld` low. Bits left over that do not fill a whole byte are dropped.
- R4: The first six bytes form the destination address, with the first received byte compared against `station_addr[7:0]`. The frame is accepted when the address equals `station_addr`, when it is all ones, or when `promisc` is high. Otherwise no byte, marker or flag update is produced for it.
- R5: With `buf_crc` high, all received bytes of an accepted frame are output. With `buf_crc` low, the last four bytes are withheld.
- R6: Each accepted frame gives exactly one `rx_sof`, on its first output byte, and exactly one `rx_eof`, on its last output byte.
- R7: `ev_crc_err` is set with `rx_eof` when the bit-reversed CRC-32 register does not equal 0xC704DD7B after all bytes of the frame. The register is reflected, uses polynomial 0x04C11DB7 and starts at all ones.
- R8: `ev_runt` is set with `rx_eof` when the frame, counting its check bytes, holds fewer than 64 bytes.
- R9: The event flags rise only together with `rx_eof`. They keep their value afterwards and clear in the cycle after the next start delimiter.
- R10: A frame with fewer than six whole bytes produces no output.
- R11: After reset all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_in | input | 1 | Serial NRZ data bit |
| bit_vld | input | 1 | Carrier valid; one bit per cycle while high |
| station_addr | input | 48 | Station address; bits [7:0] are the first byte on the wire |
| promisc | input | 1 | Accept every destination address |
| buf_crc | input | 1 | Forward the four check bytes |
| rx_byte | output | 8 | Output byte |
| rx_vld | output | 1 | Output byte valid |
| rx_sof | output | 1 | First byte of an accepted frame |
| rx_eof | output | 1 | Last byte of an accepted frame |
| ev_crc_err | output | 1 | Check-sequence mismatch in the last accepted frame |
| ev_runt | output | 1 | Last accepted frame was shorter than 64 bytes |

## Verification
The assertions assume that bits arrive on every cycle while carrier-valid is high. They also assume that at least eight idle cycles separate frames, so the end-of-frame drain always finishes before the next delimiter can arrive. They further assume that `buf_crc`, `promisc` and `station_addr` stay fixed during a frame. The stimulus drives every frame as one continuous burst of bits, follows it with twenty idle cycles, and changes the configuration only while the line is idle. It sweeps frame lengths on both sides of the 64-byte limit, both check-byte modes, good and corrupted check sequences, all four filter outcomes and several trailing-bit counts.

// File: rtl/eth_rx_pkg.sv
package eth_rx_pkg;

    localparam int BYTE_W    = 8;
    localparam int DA_LEN    = 6;
    localparam int FCS_LEN   = 4;
    localparam int MIN_FRAME = 64;
    localparam int CNT_W     = 12;
    localparam int LEFT_W    = $clog2(DA_LEN + 1);

    // delimiter as seen in a shift register whose newest bit is bit 0
    localparam logic [7:0]  SFD_PAT     = 8'b1010_1011;
    localparam logic [31:0] CRC_POLY_R  = 32'hEDB8_8320;
    localparam logic [31:0] CRC_INIT    = 32'hFFFF_FFFF;
    localparam logic [31:0] CRC_RESIDUE = 32'hC704_DD7B;

    typedef enum logic {ST_HUNT, ST_FRAME} deser_st_e;

    typedef struct packed {
        logic              vld;
        logic [BYTE_W-1:0] data;
    } byte_beat_t;

    typedef struct packed {
        logic crc_bad;
        logic runt;
    } frame_stat_t;

    // entry 0 holds the newest byte
    typedef logic [DA_LEN-1:0][BYTE_W-1:0] tap_arr_t;

    function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY_R;
            else             r = r >> 1;
        end
        return r;
    endfunction

    function automatic logic [31:0] bitrev32(input logic [31:0] v);
        logic [31:0] r;
        for (int i = 0; i < 32; i++) r[i] = v[31-i];
        return r;
    endfunction

    function automatic logic [DA_LEN*BYTE_W-1:0] da_of(input tap_arr_t t);
        logic [DA_LEN*BYTE_W-1:0] a;
        for (int i = 0; i < DA_LEN; i++) a[i*BYTE_W +: BYTE_W] = t[DA_LEN-1-i];
        return a;
    endfunction

endpackage

// File: rtl/eth_rx_deser.sv
module eth_rx_deser
    import eth_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       bit_in,
    input  logic       bit_vld,
    output logic       sfd_p,
    output logic       end_p,
    output byte_beat_t beat
);

    deser_st_e   st_q;
    logic [7:0]  hunt_q;
    logic [7:0]  shr_q;
    logic [2:0]  bcnt_q;
    logic [7:0]  hunt_nx;
    logic [7:0]  shr_nx;

    assign hunt_nx = {hunt_q[6:0], bit_in};
    assign shr_nx  = {bit_in, shr_q[7:1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_HUNT;
            hunt_q <= '0;
            shr_q  <= '0;
            bcnt_q <= '0;
            sfd_p  <= 1'b0;
            end_p  <= 1'b0;
            beat   <= '0;
        end else begin
            sfd_p    <= 1'b0;
            end_p    <= 1'b0;
            beat.vld <= 1'b0;
            case (st_q)
                ST_HUNT: begin
                    if (bit_vld) begin
                        hunt_q <= hunt_nx;
                        if (hunt_nx == SFD_PAT) begin
                            st_q   <= ST_FRAME;
                            sfd_p  <= 1'b1;
                            bcnt_q <= '0;
                        end
                    end else begin
                        hunt_q <= '0;
                    end
                end
                default: begin
                    if (bit_vld) begin
                        shr_q  <= shr_nx;
                        bcnt_q <= bcnt_q + 3'd1;
                        if (bcnt_q == 3'd7) begin
                            beat.vld  <= 1'b1;
                            beat.data <= shr_nx;
                        end
                    end else begin
                        st_q   <= ST_HUNT;
                        end_p  <= 1'b1;
                        hunt_q <= '0;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/eth_rx_crc.sv
module eth_rx_crc
    import eth_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       init,
    input  byte_beat_t beat,
    output logic       crc_ok
);

    logic [31:0] crc_q;

    always_ff @(posedge clk) begin
        if (rst || init)   crc_q <= CRC_INIT;
        else if (beat.vld) crc_q <= crc_step(crc_q, beat.data);
    end

    assign crc_ok = (bitrev32(crc_q) == CRC_RESIDUE);

endmodule

// File: rtl/eth_rx_hold.sv
module eth_rx_hold
    import eth_rx_pkg::*;
#(
    parameter int DEPTH = DA_LEN
)(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       push,
    input  logic [BYTE_W-1:0]          din,
    input  logic                       pop,
    output logic [DEPTH-1:0][BYTE_W-1:0] taps
);

    logic [DEPTH-1:0][BYTE_W-1:0] sr_q;

    always_ff @(posedge clk) begin
        if (rst)              sr_q <= '0;
        else if (push || pop) sr_q <= {sr_q[DEPTH-2:0], (push ? din : {BYTE_W{1'b0}})};
    end

    assign taps = sr_q;

endmodule

// File: rtl/eth_rx_checker.sv
module eth_rx_checker
    import eth_rx_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        bit_in,
    input  logic        bit_vld,
    input  logic [47:0] station_addr,
    input  logic        promisc,
    input  logic        buf_crc,
    output logic [7:0]  rx_byte,
    output logic        rx_vld,
    output logic        rx_sof,
    output logic        rx_eof,
    output logic        ev_crc_err,
    output logic        ev_runt
);

    logic              sfd_p, end_p, crc_ok;
    byte_beat_t        beat;
    tap_arr_t          taps;
    logic [CNT_W-1:0]  nbytes_q;
    logic              dec_q, acc_q, drain_q, emitted_q;
    logic [LEFT_W-1:0] left_q;
    frame_stat_t       stat_q;
    logic [47:0]       da;
    logic              match_now, acc_now, full, emit_live, last_drain, out_any;

    eth_rx_deser u_deser (
        .clk(clk), .rst(rst), .bit_in(bit_in), .bit_vld(bit_vld),
        .sfd_p(sfd_p), .end_p(end_p), .beat(beat)
    );

    eth_rx_crc u_crc (
        .clk(clk), .rst(rst), .init(sfd_p), .beat(beat), .crc_ok(crc_ok)
    );

    eth_rx_hold #(.DEPTH(DA_LEN)) u_hold (
        .clk(clk), .rst(rst), .push(beat.vld), .din(beat.data),
        .pop(drain_q), .taps(taps)
    );

    assign da         = da_of(taps);
    assign match_now  = promisc | (da == station_addr) | (&da);
    assign acc_now    = dec_q ? acc_q : match_now;
    assign full       = (nbytes_q >= CNT_W'(DA_LEN));
    assign emit_live  = beat.vld & full & acc_now;
    assign last_drain = drain_q & (left_q == LEFT_W'(1));
    assign out_any    = emit_live | drain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_byte    <= '0;
            rx_vld     <= 1'b0;
            rx_sof     <= 1'b0;
            rx_eof     <= 1'b0;
            ev_crc_err <= 1'b0;
            ev_runt    <= 1'b0;
            nbytes_q   <= '0;
            dec_q      <= 1'b0;
            acc_q      <= 1'b0;
            drain_q    <= 1'b0;
            emitted_q  <= 1'b0;
            left_q     <= '0;
            stat_q     <= '0;
        end else begin
            rx_vld  <= out_any;
            rx_byte <= taps[DA_LEN-1];
            rx_sof  <= out_any & ~emitted_q;
            rx_eof  <= last_drain;
            if (out_any) emitted_q <= 1'b1;

            if (sfd_p) begin
                nbytes_q   <= '0;
                dec_q      <= 1'b0;
                acc_q      <= 1'b0;
                emitted_q  <= 1'b0;
                ev_crc_err <= 1'b0;
                ev_runt    <= 1'b0;
            end else begin
                if (beat.vld && nbytes_q != '1)
                    nbytes_q <= nbytes_q + CNT_W'(1);
                if (nbytes_q == CNT_W'(DA_LEN) && !dec_q) begin
                    dec_q <= 1'b1;
                    acc_q <= match_now;
                end
                if (end_p && full && acc_now) begin
                    drain_q        <= 1'b1;
                    left_q         <= buf_crc ? LEFT_W'(DA_LEN) : LEFT_W'(DA_LEN - FCS_LEN);
                    stat_q.crc_bad <= ~crc_ok;
                    stat_q.runt    <= (nbytes_q < CNT_W'(MIN_FRAME));
                end
                if (drain_q) begin
                    left_q <= left_q - LEFT_W'(1);
                    if (last_drain) begin
                        drain_q    <= 1'b0;
                        ev_crc_err <= stat_q.crc_bad;
                        ev_runt    <= stat_q.runt;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/eth_rx_checker_sva.sv
module eth_rx_checker_sva (
    input logic clk,
    input logic rst,
    input logic rx_vld,
    input logic rx_sof,
    input logic rx_eof,
    input logic ev_crc_err,
    input logic ev_runt
);

    // R6: markers only ride on valid bytes
    p_sof_on_byte_r6: assert property (@(posedge clk) disable iff (rst) rx_sof |-> rx_vld);
    p_eof_on_byte_r6: assert property (@(posedge clk) disable iff (rst) rx_eof |-> rx_vld);
    // R6: nothing follows the end marker directly
    p_eof_then_quiet_r6: assert property (@(posedge clk) disable iff (rst) rx_eof |=> !rx_vld);
    // R9: flags may only rise alongside the end marker
    p_crc_flag_rise_r9: assert property (@(posedge clk) disable iff (rst) $rose(ev_crc_err) |-> rx_eof);
    p_runt_flag_rise_r9: assert property (@(posedge clk) disable iff (rst) $rose(ev_runt) |-> rx_eof);
    // R6: start and end markers of one frame never collide with a second start
    p_one_marker_r6: assert property (@(posedge clk) disable iff (rst) (rx_sof && !rx_eof) |=> !rx_sof);

endmodule

bind eth_rx_checker eth_rx_checker_sva u_sva (
    .clk(clk), .rst(rst), .rx_vld(rx_vld), .rx_sof(rx_sof), .rx_eof(rx_eof),
    .ev_crc_err(ev_crc_err), .ev_runt(ev_runt)
);

// File: tb/eth_rx_checker_test.sv
`timescale 1ns/100ps
module eth_rx_checker_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bit_in = 1'b0;
    logic        bit_vld = 1'b0;
    logic [47:0] station_addr = 48'h0A1B_2C3D_4E5F;
    logic        promisc = 1'b0;
    logic        buf_crc = 1'b0;
    logic [7:0]  rx_byte;
    logic        rx_vld, rx_sof, rx_eof, ev_crc_err, ev_runt;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    logic [7:0] fr  [0:127];
    logic [7:0] cap [0:255];
    int cap_n = 0, sof_cnt = 0, sof_idx = -1, eof_cnt = 0, eof_idx = -1;
    logic cap_crc = 1'b0, cap_runt = 1'b0;
    logic exp_crc_flag = 1'b0, exp_runt_flag = 1'b0;

    eth_rx_checker uut (
        .clk(clk), .rst(rst), .bit_in(bit_in), .bit_vld(bit_vld),
        .station_addr(station_addr), .promisc(promisc), .buf_crc(buf_crc),
        .rx_byte(rx_byte), .rx_vld(rx_vld), .rx_sof(rx_sof), .rx_eof(rx_eof),
        .ev_crc_err(ev_crc_err), .ev_runt(ev_runt)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc == 190000) begin
            fails++;
            $display("FAIL R11 watchdog: actual cycles=%0d expected below %0d", cyc, 190000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    always @(negedge clk) begin
        if (!rst && rx_vld) begin
            if (cap_n < 256) cap[cap_n] = rx_byte;
            if (rx_sof) begin sof_cnt++; sof_idx = cap_n; end
            if (rx_eof) begin
                eof_cnt++; eof_idx = cap_n;
                cap_crc = ev_crc_err; cap_runt = ev_runt;
            end
            cap_n++;
        end
    end

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        bit_in  = b;
        bit_vld = 1'b1;
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) send_bit(v[i]);
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            bit_vld = 1'b0;
            bit_in  = 1'b0;
        end
    endtask

    // 0: own address, 1: broadcast, 2: foreign
    task automatic build(input int len, input int da_kind, input bit corrupt);
        logic [31:0] c;
        for (int i = 0; i < 6; i++) begin
            case (da_kind)
                0: fr[i] = station_addr[i*8 +: 8];
                1: fr[i] = 8'hFF;
                default: fr[i] = 8'h10 + 8'(i);
            endcase
        end
        for (int i = 6; i < len - 4; i++) fr[i] = 8'((i * 37 + len) & 255);
        c = 32'hFFFF_FFFF;
        for (int i = 0; i < len - 4; i++)
            for (int b = 0; b < 8; b++)
                c = (c[0] ^ fr[i][b]) ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
        c = ~c;
        for (int i = 0; i < 4; i++) fr[len - 4 + i] = c[i*8 +: 8];
        if (corrupt) fr[len - 1] = fr[len - 1] ^ 8'h01;
    endtask

    task automatic send_frame(input int len, input int pre_bytes, input int trail);
        cap_n = 0; sof_cnt = 0; sof_idx = -1; eof_cnt = 0; eof_idx = -1;
        // R9: flags from the previous frame still hold while idle
        chk(ev_crc_err == exp_crc_flag, "R9 crc flag held", int'(ev_crc_err), int'(exp_crc_flag));
        chk(ev_runt == exp_runt_flag, "R9 runt flag held", int'(ev_runt), int'(exp_runt_flag));
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
        for (int i = 0; i < pre_bytes; i++) send_byte(8'h55);
        send_byte(8'hD5);
        for (int i = 0; i < len; i++) begin
            send_byte(fr[i]);
            if (i == 1) begin
                chk(ev_crc_err == 1'b0, "R9 crc flag cleared after delimiter", int'(ev_crc_err), 0);
                chk(ev_runt == 1'b0, "R9 runt flag cleared after delimiter", int'(ev_runt), 0);
            end
        end
        for (int i = 0; i < trail; i++) send_bit(1'(i & 1));
        idle(20);
    endtask

    task automatic expect_frame(input int len, input bit acc, input bit corrupt, input int trail);
        int exp_n, bad;
        if (!acc || len < 6) begin
            // R4 and R10: nothing leaves the block
            chk(cap_n == 0 && eof_cnt == 0, "R4 R10 rejected frame output count", cap_n, 0);
            exp_crc_flag = 1'b0;
            exp_runt_flag = 1'b0;
            return;
        end
        exp_n = buf_crc ? len : len - 4;
        chk(cap_n == exp_n, $sformatf("R5 R3 R1 byte count (buf_crc=%0d trail=%0d)", buf_crc, trail), cap_n, exp_n);
        bad = 0;
        for (int i = 0; i < exp_n && i < cap_n; i++) if (cap[i] !== fr[i]) bad++;
        chk(bad == 0, "R2 byte content mismatches", bad, 0);
        chk(sof_cnt == 1 && sof_idx == 0, "R6 start marker position", sof_idx, 0);
        chk(eof_cnt == 1 && eof_idx == exp_n - 1, "R6 end marker position", eof_idx, exp_n - 1);
        chk(cap_crc == corrupt, "R7 crc error flag", int'(cap_crc), int'(corrupt));
        chk(cap_runt == (len < 64), "R8 runt flag", int'(cap_runt), int'(len < 64));
        exp_crc_flag  = corrupt;
        exp_runt_flag = (len < 64);
    endtask

    int lens [0:7] = '{10, 11, 18, 59, 63, 64, 65, 90};

    initial begin
        repeat (4) @(negedge clk);
        // R11: reset state
        chk({rx_vld, rx_sof, rx_eof, ev_crc_err, ev_runt, rx_byte} == '0, "R11 outputs during reset",
            int'({rx_vld, rx_sof, rx_eof, ev_crc_err, ev_runt}), 0);
        rst = 1'b0;
        idle(4);
        chk({rx_vld, rx_sof, rx_eof, ev_crc_err, ev_runt} == '0, "R11 outputs after reset",
            int'({rx_vld, rx_sof, rx_eof, ev_crc_err, ev_runt}), 0);

        // own address: lengths x check-byte mode x corruption
        for (int li = 0; li < 8; li++)
            for (int bc = 0; bc < 2; bc++)
                for (int cr = 0; cr < 2; cr++) begin
                    buf_crc = 1'(bc);
                    build(lens[li], 0, 1'(cr));
                    send_frame(lens[li], 2 + (li % 6), (lens[li] + bc + cr) % 6);
                    expect_frame(lens[li], 1'b1, 1'(cr), (lens[li] + bc + cr) % 6);
                end

        // filter outcomes
        for (int k = 0; k < 4; k++)
            for (int li = 0; li < 2; li++) begin
                int l;
                l = li ? 70 : 20;
                buf_crc = 1'(k & 1);
                promisc = (k == 3);
                build(l, (k == 0) ? 0 : (k == 1) ? 1 : 2, 1'(li));
                send_frame(l, 7, 3);
                expect_frame(l, k != 2, 1'(li), 3);
            end
        promisc = 1'b0;

        // R10: frames too short to carry a whole address
        for (int l = 1; l < 6; l++) begin
            for (int i = 0; i < l; i++) fr[i] = station_addr[i*8 +: 8];
            send_frame(l, 7, 2);
            expect_frame(l, 1'b1, 1'b0, 2);
        end

        // R1: a lone delimiter with no preamble still starts a frame
        buf_crc = 1'b1;
        build(12, 0, 1'b0);
        send_frame(12, 0, 0);
        expect_frame(12, 1'b1, 1'b0, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule